// File: doc/BRIEF.md
# Adaptive Insertion Replacement Controller with Set Dueling

This block keeps a full recency order for every set of a set-associative cache and names the way to evict. Each way of a set has an age from 0 (most recent) to WAYS-1 (least recent). A hit moves the touched way to age 0. When a line is filled, the block either places it at age 0, as plain LRU does, or leaves it at the oldest age. In the second case a line that is never reused is the next one evicted, and lines that have been reused are protected from scans.

Which insertion rule a set uses is decided by a duel. Sets whose index modulo DUEL_PERIOD is 0 always insert at the newest position. Sets whose index modulo DUEL_PERIOD is 1 always insert at the oldest position. Misses reported in these two leader groups move a saturating selector counter up or down. All other sets follow the current winner, which is read from the counter's top bit. Tag and data arrays live outside the block; the block only receives hit, fill and miss events and returns the victim way for a queried set.

Top module: `dip_lru_repl`

## Requirements
- R1: After reset, every way w of every set has age w, so the victim of any set is way WAYS-1. The selector starts at 2^(SEL_W-1), which has its top bit set, so follower sets begin with oldest-position insertion.
- R2: A hit on way w of set s sets the age of w to 0. Every way of s with an age below the old age of w moves one age older. All other ways and sets are unchanged.
- R3: A fill into a set whose index modulo DUEL_PERIOD is 0 always inserts the way at age 0, with the same aging rule as a hit.
- R4: A fill into a set whose index modulo DUEL_PERIOD is 1 always gives the filled way age WAYS-1. Every way older than the filled way's previous age moves one step younger, so the filled way becomes the victim.
- R5: A fill into any other set inserts at age WAYS-1 (as in R4) while the selector's top bit is 1, and at age 0 (as in R3) while it is 0.
- R6: A miss in a set with index modulo DUEL_PERIOD equal to 0 adds one to the selector. A miss in a set with index modulo DUEL_PERIOD equal to 1 subtracts one. A miss in any other set leaves the selector unchanged.
- R7: The selector saturates at 2^SEL_W-1 and at 0 and never wraps.
- R8: vic_way is the way of set vic_set whose age is WAYS-1. It follows vic_set combinationally and reflects updates from the previous clock edge.
- R9: If a fill and a hit target the same set in one cycle, only the fill is applied. If they target different sets, both are applied.
- R10: The ages within each set always form a permutation of 0..WAYS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_vld | input | 1 | A hit occurred this cycle |
| hit_set | input | SET_W | Set index of the hit |
| hit_way | input | WAY_W | Way that hit |
| fill_vld | input | 1 | A line is being installed this cycle |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Way receiving the line |
| miss_vld | input | 1 | A miss occurred this cycle |
| miss_set | input | SET_W | Set index of the miss |
| vic_set | input | SET_W | Set whose victim is requested |
| vic_way | output | WAY_W | Oldest way of vic_set |

## Verification
The assertions assume that hit_way and fill_way are valid way numbers and that the event ports carry set indices inside the array. With these inputs the age permutation cannot be broken from outside. The stimulus uses only in-range ways and sets. It drives hits and fills to the same set in one cycle only in the directed test for R9. Misses are issued in long runs, one per cycle, so that the selector reaches both of its limits. Its value is then read back indirectly through the insertion position of a follower fill.

// File: rtl/dip_lru_repl.sv
module dip_lru_repl #(
  parameter int WAYS        = 4,
  parameter int SETS        = 64,
  parameter int SEL_W       = 10,
  parameter int DUEL_PERIOD = 32,
  localparam int WAY_W      = $clog2(WAYS),
  localparam int SET_W      = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_vld,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_vld,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             miss_vld,
  input  logic [SET_W-1:0] miss_set,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);

  typedef logic [WAY_W-1:0] age_t;

  localparam age_t             AGE_OLD = age_t'(WAYS - 1);
  localparam logic [SEL_W-1:0] SEL_MAX = '1;
  localparam logic [SEL_W-1:0] SEL_MID = {1'b1, {(SEL_W-1){1'b0}}};

  age_t             ages [SETS][WAYS];
  logic [SEL_W-1:0] sel;
  logic [WAYS-1:0]  lru_hot;

  function automatic age_t to_new(age_t cur, age_t ref_age, logic self);
    if (self)               return '0;
    else if (cur < ref_age) return cur + age_t'(1);
    else                    return cur;
  endfunction

  function automatic age_t to_old(age_t cur, age_t ref_age, logic self);
    if (self)               return AGE_OLD;
    else if (cur > ref_age) return cur - age_t'(1);
    else                    return cur;
  endfunction

  function automatic logic set_rem_is(logic [SET_W-1:0] s, int rem);
    return (int'(s) % DUEL_PERIOD) == rem;
  endfunction

  logic fill_new_ldr, fill_old_ldr, miss_new_ldr, miss_old_ldr, fill_at_old;
  assign fill_new_ldr = set_rem_is(fill_set, 0);
  assign fill_old_ldr = set_rem_is(fill_set, 1);
  assign miss_new_ldr = set_rem_is(miss_set, 0);
  assign miss_old_ldr = set_rem_is(miss_set, 1);
  assign fill_at_old  = fill_old_ldr | (!fill_new_ldr & sel[SEL_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ages[s][w] <= age_t'(w);
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (fill_vld && fill_set == SET_W'(s)) begin
          for (int w = 0; w < WAYS; w++)
            ages[s][w] <= fill_at_old
              ? to_old(ages[s][w], ages[s][fill_way], fill_way == WAY_W'(w))
              : to_new(ages[s][w], ages[s][fill_way], fill_way == WAY_W'(w));
        end else if (hit_vld && hit_set == SET_W'(s)) begin
          for (int w = 0; w < WAYS; w++)
            ages[s][w] <= to_new(ages[s][w], ages[s][hit_way], hit_way == WAY_W'(w));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel <= SEL_MID;
    else if (miss_vld && miss_new_ldr && sel != SEL_MAX)
      sel <= sel + 1'b1;
    else if (miss_vld && miss_old_ldr && sel != '0)
      sel <= sel - 1'b1;
  end

  always_comb begin
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      lru_hot[w] = (ages[vic_set][w] == AGE_OLD);
      if (lru_hot[w]) vic_way = WAY_W'(w);
    end
  end

  AST_VICTIM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lru_hot) == 1); // R10

  AST_HIT_TO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && !(fill_vld && fill_set == hit_set))
    |=> ages[$past(hit_set)][$past(hit_way)] == '0); // R2

  AST_FILL_NEW_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && fill_new_ldr)
    |=> ages[$past(fill_set)][$past(fill_way)] == '0); // R3

  AST_FILL_OLD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && fill_old_ldr)
    |=> ages[$past(fill_set)][$past(fill_way)] == AGE_OLD); // R4

  AST_SEL_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MAX) |=> (sel != '0)); // R7

  AST_SEL_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> (sel != SEL_MAX)); // R7

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss_vld && (miss_new_ldr || miss_old_ldr)) |=> $stable(sel)); // R6

endmodule

// File: tb/tb_dip_lru_repl.sv
module tb_dip_lru_repl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit_vld = 1'b0, fill_vld = 1'b0, miss_vld = 1'b0;
  logic [5:0] hit_set = '0, fill_set = '0, miss_set = '0, vic_set = '0;
  logic [1:0] hit_way = '0, fill_way = '0;
  logic [1:0] vic_way;
  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dip_lru_repl dut (
    .clk(clk), .rst_n(rst_n),
    .hit_vld(hit_vld), .hit_set(hit_set), .hit_way(hit_way),
    .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way),
    .miss_vld(miss_vld), .miss_set(miss_set),
    .vic_set(vic_set), .vic_way(vic_way)
  );

  // {op(0 hit,1 fill,2 miss), set, way, expected victim of that set}
  localparam logic [11:0] VEC [17] = '{
    {2'd1, 6'd0,  2'd3, 2'd2},  // R3
    {2'd0, 6'd0,  2'd2, 2'd1},  // R2
    {2'd1, 6'd1,  2'd3, 2'd3},  // R4
    {2'd0, 6'd1,  2'd3, 2'd2},  // R2
    {2'd1, 6'd1,  2'd2, 2'd2},  // R4
    {2'd1, 6'd5,  2'd3, 2'd3},  // R5
    {2'd0, 6'd5,  2'd0, 2'd3},  // R2
    {2'd0, 6'd5,  2'd3, 2'd2},  // R2
    {2'd1, 6'd5,  2'd1, 2'd1},  // R5
    {2'd0, 6'd5,  2'd1, 2'd2},  // R2
    {2'd2, 6'd1,  2'd0, 2'd2},  // R6
    {2'd1, 6'd6,  2'd3, 2'd2},  // R5
    {2'd1, 6'd33, 2'd0, 2'd0},  // R4
    {2'd1, 6'd32, 2'd0, 2'd3},  // R3
    {2'd0, 6'd6,  2'd2, 2'd1},  // R2
    {2'd2, 6'd0,  2'd0, 2'd1},  // R6
    {2'd1, 6'd7,  2'd1, 2'd1}   // R5
  };

  task automatic check(input int got, input int exp, input string req);
    nchk++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic op(input logic [1:0] kind, input logic [5:0] s, input logic [1:0] w);
    @(negedge clk);
    hit_vld  = (kind == 2'd0); hit_set  = s; hit_way  = w;
    fill_vld = (kind == 2'd1); fill_set = s; fill_way = w;
    miss_vld = (kind == 2'd2); miss_set = s;
    @(negedge clk);
    hit_vld = 1'b0; fill_vld = 1'b0; miss_vld = 1'b0;
    vic_set = s;
    #1;
  endtask

  task automatic misses(input logic [5:0] s, input int n);
    @(negedge clk);
    miss_vld = 1'b1; miss_set = s;
    repeat (n) @(negedge clk);
    miss_vld = 1'b0;
  endtask

  task automatic fill_probe(input logic [5:0] s, input int exp, input string req);
    op(2'd1, s, 2'd3);
    check(vic_way, exp, req);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    vic_set = 6'd0;  #1; check(vic_way, 3, "R1 reset set0");
    vic_set = 6'd31; #1; check(vic_way, 3, "R1 reset set31");
    vic_set = 6'd63; #1; check(vic_way, 3, "R8 reset set63");

    for (int i = 0; i < 17; i++) begin
      op(VEC[i][11:10], VEC[i][9:4], VEC[i][3:2]);
      check(vic_way, VEC[i][1:0], $sformatf("R2-R6 vector %0d", i));
    end

    do_reset();
    fill_probe(6'd20, 3, "R1 selector midpoint");

    do_reset();
    @(negedge clk);
    fill_vld = 1'b1; fill_set = 6'd14; fill_way = 2'd3;
    hit_vld  = 1'b1; hit_set  = 6'd14; hit_way  = 2'd3;
    @(negedge clk);
    fill_vld = 1'b0; hit_vld = 1'b0; vic_set = 6'd14; #1;
    check(vic_way, 3, "R9 same set fill wins");
    @(negedge clk);
    fill_vld = 1'b1; fill_set = 6'd15; fill_way = 2'd3;
    hit_vld  = 1'b1; hit_set  = 6'd16; hit_way  = 2'd3;
    @(negedge clk);
    fill_vld = 1'b0; hit_vld = 1'b0;
    vic_set = 6'd15; #1; check(vic_way, 3, "R9 fill other set");
    vic_set = 6'd16; #1; check(vic_way, 2, "R9 hit other set");

    do_reset();
    misses(6'd0, 600);
    misses(6'd1, 511);
    fill_probe(6'd9, 3, "R7 top saturation");
    misses(6'd1, 1);
    fill_probe(6'd10, 2, "R7 top saturation flip");
    misses(6'd1, 1100);
    misses(6'd0, 511);
    fill_probe(6'd11, 2, "R7 bottom saturation");
    misses(6'd0, 1);
    fill_probe(6'd12, 3, "R7 bottom saturation flip");
    misses(6'd2, 3);
    fill_probe(6'd13, 3, "R6 follower miss ignored");
    misses(6'd33, 1);
    fill_probe(6'd17, 2, "R6 leader by modulo");

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule